// File: doc/BRIEF.md
# Serial Configuration and Status Port

This block is the slave end of a three-wire link between a microcontroller and a radio receiver. The controller frames each transfer with an active-high enable, supplies the bit clock itself, and shares one open-drain data line with the slave. The line is pulled high by a weak resistor and pulled low by whichever side sends a zero.

A transfer opens with a two-bit opcode. The opcode selects one of four operations:
- write the 9-bit setup word,
- read the setup word back,
- read a 4-bit status word,
- stream out a 16-byte buffer of received payload.

Every read leaves one idle bit slot after the opcode, and the slave drives the line only after that slot. The receive path reports each finished message with a one-cycle strobe and a packet-count code. That strobe sets a message flag, and the flag is also the interrupt to the controller. A complete status read clears the flag. The buffer is filled by the receive path through a simple write port.

The bit clock, enable and line are resampled into the system clock domain, so the bit clock must run several times slower than the system clock.

Top module: `ucfg_serial_port`

## Requirements
- R1: The first opcode bit on the line is the opcode MSB. Opcode 01 writes setup, 00 reads setup, 10 reads status and 11 reads the data buffer.
- R2: A setup write takes 9 bits, MSB (bit 8) first. `cfg` changes only once the ninth bit has been sampled, and the write sets it to exactly the 9 bits sent.
- R3: On every read opcode, the bit slot that follows the opcode leaves the line released (high).
- R4: The slave only ever pulls the line low, and only for a 0 data bit. Within a few system clocks of enable going low, it releases the line.
- R5: A setup read returns the current `cfg` value, MSB first.
- R6: The status word is sent bit 0 first. Bit 0 is the message flag, bit 1 is `rx_active`, and bits 3:2 are the packet code.
- R7: A `msg_done` pulse sets the message flag and latches `rq_in` as the packet code. The code 00 means 1 packet, 01 means 2, 10 means 3 and 11 means 4. `irq` is high while the flag is set.
- R8: Once all 4 status bits have been clocked out, the message flag and `irq` clear. A status read aborted earlier leaves them set.
- R9: A data read sends all 16 buffer bytes, byte 0 first and each byte LSB first.
- R10: Dropping enable mid-transfer aborts it. A partial write leaves `cfg` unchanged, and the next transfer starts with a fresh opcode.
- R11: Input bits are sampled on the rising bit-clock edge. Output bits change only after a falling edge, so the line holds steady through each high phase.
- R12: After reset, `cfg` is 0, the message flag and `irq` are 0, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Bit clock from the controller |
| en | input | 1 | Active-high transfer frame |
| sd_in | input | 1 | Level seen on the shared data line |
| sd_drive_low | output | 1 | Pull the data line low when 1 |
| rx_active | input | 1 | Receive path is busy with a packet |
| msg_done | input | 1 | One-cycle strobe: a message completed |
| rq_in | input | 2 | Packet-count code carried with `msg_done` |
| buf_we | input | 1 | Payload buffer write strobe |
| buf_addr | input | 4 | Payload buffer byte address |
| buf_wdata | input | 8 | Payload buffer write byte |
| irq | output | 1 | Interrupt, high while the message flag is set |
| cfg | output | 9 | Current setup word |

## Verification
Most internal faults show up as a wrong bit on the line during a read. A slipped bit counter, a swapped opcode or a reversed bit order corrupts the very first data slot after the idle slot, a few bit times into the transfer. A turnaround or drive-timing error shows as a low level in the idle slot, or as a change during a high phase. A flag fault shows on `irq` right after a `msg_done` pulse or right after a full status read. An abort fault shows on `cfg` and on the line as soon as enable falls.

// File: rtl/ucfg_serial_port.sv
module ucfg_serial_port #(
  parameter int CFG_W     = 9,
  parameter int BUF_BYTES = 16,
  parameter int AW        = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             en,
  input  logic             sd_in,
  output logic             sd_drive_low,
  input  logic             rx_active,
  input  logic             msg_done,
  input  logic [1:0]       rq_in,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_wdata,
  output logic             irq,
  output logic [CFG_W-1:0] cfg
);
  localparam int DATA_BITS = 8 * BUF_BYTES;
  localparam int PW        = $clog2(DATA_BITS + 1);
  localparam int CW        = $clog2(CFG_W);

  localparam logic [1:0] OP_RSET  = 2'b00;
  localparam logic [1:0] OP_WSET  = 2'b01;
  localparam logic [1:0] OP_RSTAT = 2'b10;

  typedef enum logic [2:0] {S_OP, S_WR, S_TA, S_RD, S_END} st_t;

  st_t             state;
  logic [2:0]      sy_clk;
  logic [1:0]      sy_en, sy_sd;
  logic [1:0]      op;
  logic [PW-1:0]   cnt;
  logic [CFG_W-1:0] wsh;
  logic [3:0]      snap;
  logic            dr, out_bit, rd_on;
  logic [1:0]      rq;
  logic [7:0]      mem [BUF_BYTES];
  logic [PW-1:0]   rd_len;
  logic [CW-1:0]   cidx;
  logic            cur_bit, stat_clr;

  wire rise   = sy_clk[1] & ~sy_clk[2];
  wire fall   = ~sy_clk[1] & sy_clk[2];
  wire en_s   = sy_en[1];
  wire bit_in = sy_sd[1];

  assign irq          = dr;
  assign sd_drive_low = rd_on & ~out_bit;
  assign cidx         = CW'(CFG_W - 1) - cnt[CW-1:0];
  assign stat_clr     = rise && state == S_RD && op == OP_RSTAT && cnt == PW'(4) && rd_on;

  always_comb begin
    case (op)
      OP_RSET:  rd_len = PW'(CFG_W);
      OP_RSTAT: rd_len = PW'(4);
      default:  rd_len = PW'(DATA_BITS);
    endcase
    case (op)
      OP_RSET:  cur_bit = cfg[cidx];
      OP_RSTAT: cur_bit = snap[cnt[1:0]];
      default:  cur_bit = mem[cnt[AW+2:3]][cnt[2:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy_clk <= '0; sy_en <= '0; sy_sd <= 2'b11;
      state <= S_OP; op <= '0; cnt <= '0; wsh <= '0; snap <= '0;
      out_bit <= 1'b1; rd_on <= 1'b0; cfg <= '0;
    end else begin
      sy_clk <= {sy_clk[1:0], sclk};
      sy_en  <= {sy_en[0], en};
      sy_sd  <= {sy_sd[0], sd_in};
      if (!en_s) begin
        state <= S_OP; op <= '0; cnt <= '0; rd_on <= 1'b0;
      end else begin
        case (state)
          S_OP: if (rise) begin
            op <= {op[0], bit_in};
            if (cnt == PW'(1)) begin
              cnt   <= '0;
              state <= ({op[0], bit_in} == OP_WSET) ? S_WR : S_TA;
            end else cnt <= cnt + 1'b1;
          end
          S_WR: if (rise) begin
            wsh <= {wsh[CFG_W-2:0], bit_in};
            cnt <= cnt + 1'b1;
            if (cnt == PW'(CFG_W - 1)) begin
              cfg   <= {wsh[CFG_W-2:0], bit_in};
              state <= S_END;
            end
          end
          S_TA: if (rise) begin
            state <= S_RD;
            cnt   <= '0;
            snap  <= {rq, rx_active, dr};
          end
          S_RD: if (fall) begin
            if (cnt < rd_len) begin
              out_bit <= cur_bit;
              rd_on   <= 1'b1;
              cnt     <= cnt + 1'b1;
            end else rd_on <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr <= 1'b0; rq <= '0;
    end else if (msg_done) begin
      dr <= 1'b1; rq <= rq_in;
    end else if (stat_clr) begin
      dr <= 1'b0;
    end
  end

  // R3: idle slot after a read opcode
  a_r3_turnaround_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_TA |-> !sd_drive_low);
  a_r4_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !sd_drive_low);
  a_r4_drive_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    sd_drive_low |-> state == S_RD);
  a_r11_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && !fall) |=> $stable(sd_drive_low));
  a_r2_cfg_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_WR |=> $stable(cfg));
  a_r7_flag_on_msg: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> irq);
  a_r8_clear_by_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(state == S_RD && op == OP_RSTAT));
endmodule

// File: tb/sim_ucfg_serial_port.sv
module sim_ucfg_serial_port;
  logic clk = 0, rst_n = 0, sclk = 0, en = 0;
  logic rx_active = 0, msg_done = 0, buf_we = 0;
  logic [1:0] rq_in = 0;
  logic [3:0] buf_addr = 0;
  logic [7:0] buf_wdata = 0;
  logic sd_drive_low, irq;
  logic [8:0] cfg;
  logic m_drv = 0, m_val = 1;
  logic line;
  int compared = 0, mismatched = 0;
  logic [127:0] dexp;

  assign line = sd_drive_low ? 1'b0 : (m_drv ? m_val : 1'b1);

  always #10 clk = ~clk;

  ucfg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .en(en), .sd_in(line),
    .sd_drive_low(sd_drive_low), .rx_active(rx_active), .msg_done(msg_done),
    .rq_in(rq_in), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .irq(irq), .cfg(cfg));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic drv, input logic val, output logic lo, output logic hi);
    m_drv = drv; m_val = val;
    repeat (6) @(negedge clk);
    lo = line;
    sclk = 1;
    repeat (3) @(negedge clk);
    hi = line;
    repeat (3) @(negedge clk);
    sclk = 0;
  endtask

  task automatic tx_open();
    en = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_close();
    m_drv = 0;
    repeat (6) @(negedge clk);
    en = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input logic [8:0] v, input int nbits);
    logic a, b;
    tx_open();
    slot(1, 0, a, b);
    slot(1, 1, a, b);
    for (int i = 0; i < nbits; i++) slot(1, v[8-i], a, b);
    tx_close();
  endtask

  task automatic do_read(input logic [1:0] op, input int n, output logic [127:0] got,
                         output logic steady);
    logic a, b;
    got = '0; steady = 1;
    tx_open();
    slot(1, op[1], a, b);
    slot(1, op[0], a, b);
    slot(0, 1, a, b);
    chk("R3 turnaround slot released", {127'b0, a}, 128'd1);
    for (int k = 0; k < n; k++) begin
      slot(0, 1, a, b);
      got[k] = a;
      if (a !== b) steady = 0;
    end
    tx_close();
  endtask

  task automatic t_reset();
    chk("R12 cfg after reset", {119'b0, cfg}, 128'd0);
    chk("R12 irq after reset", {127'b0, irq}, 128'd0);
    chk("R12 line released", {127'b0, sd_drive_low}, 128'd0);
  endtask

  task automatic t_setup(input logic [8:0] v);
    logic [127:0] got; logic st; logic [8:0] rev;
    do_write(v, 9);
    chk("R2 R1 cfg after write", {119'b0, cfg}, {119'b0, v});
    do_read(2'b00, 9, got, st);
    for (int i = 0; i < 9; i++) rev[8-i] = got[i];
    chk("R5 setup readback MSB first", {119'b0, rev}, {119'b0, v});
    chk("R11 line steady in high phase", {127'b0, st}, 128'd1);
  endtask

  task automatic t_abort_write();
    logic [127:0] got; logic st; logic [8:0] rev;
    logic [8:0] keep;
    keep = cfg;
    do_write(9'h0F3, 4);
    chk("R10 partial write discarded", {119'b0, cfg}, {119'b0, keep});
    do_read(2'b00, 9, got, st);
    for (int i = 0; i < 9; i++) rev[8-i] = got[i];
    chk("R10 next transfer decodes fresh opcode", {119'b0, rev}, {119'b0, keep});
  endtask

  task automatic t_status();
    logic [127:0] got; logic st;
    rx_active = 1;
    do_read(2'b10, 4, got, st);
    chk("R6 status idle with rx busy", got, 128'b0010);
    @(negedge clk); rq_in = 2'b10; msg_done = 1;
    @(negedge clk); msg_done = 0; rq_in = 2'b00;
    @(negedge clk);
    chk("R7 irq after msg_done", {127'b0, irq}, 128'd1);
    do_read(2'b10, 2, got, st);
    chk("R8 partial status read keeps irq", {127'b0, irq}, 128'd1);
    do_read(2'b10, 4, got, st);
    chk("R6 R7 status with message, code 10", got, 128'b1011);
    chk("R8 irq cleared by full status read", {127'b0, irq}, 128'd0);
    rx_active = 0;
    do_read(2'b10, 4, got, st);
    chk("R8 flag stays clear, R7 code held", got, 128'b1000);
  endtask

  task automatic t_data();
    logic [127:0] got; logic st;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      buf_we = 1; buf_addr = 4'(i); buf_wdata = 8'(i * 29 + 7);
      for (int b = 0; b < 8; b++) dexp[8*i+b] = buf_wdata[b];
    end
    @(negedge clk); buf_we = 0;
    do_read(2'b11, 128, got, st);
    chk("R9 R1 data buffer stream", got, dexp);
  endtask

  task automatic t_abort_read();
    logic a, b;
    tx_open();
    slot(1, 1, a, b);
    slot(1, 1, a, b);
    slot(0, 1, a, b);
    for (int k = 0; k < 5; k++) slot(0, 1, a, b);
    en = 0;
    repeat (6) @(negedge clk);
    chk("R4 line released after enable drop", {126'b0, sd_drive_low, line}, 128'b01);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_setup(9'h1A5);
    t_setup(9'h05A);
    t_abort_write();
    t_status();
    t_data();
    t_abort_read();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule